// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the memory sequence a CPU core needs when it enters an exception handler or comes back from one. It accepts three hardware requests (abort, a non-maskable interrupt and a level-sensitive maskable interrupt) and three requests from the instruction decoder: the break trap, the coprocessor trap and return-from-interrupt. For an entry it writes the return state to the stack one byte at a time. It then updates the status byte, clears the program bank and reads the 16-bit handler address from the vector area at the top of bank zero. A return reads the saved state back from the stack.

The core presents its current PC, program bank, status byte and stack pointer, together with the emulation flag. The sequencer latches these values when it accepts a request and works on private copies. When it has finished it pulses `done`, and the core copies the new PC, bank, status and stack pointer from the result outputs. Memory is a byte-wide synchronous port: a read issued in one cycle returns its data in the next cycle. In emulation mode the stack stays in page 0x01 and no bank byte is saved or restored.

The state machine has these states. `ST_IDLE` waits for a request. The entry path runs `ST_PUSH_BANK` (native only), `ST_PUSH_PCH`, `ST_PUSH_PCL`, `ST_PUSH_STAT`, `ST_VEC_LO` and `ST_VEC_HI`. The return path runs `ST_PULL_STAT`, `ST_PULL_PCL`, `ST_PULL_PCH` and `ST_PULL_BANK` (native only). Both paths then pass through `ST_LAST_RD`, which captures the final read byte, and `ST_DONE`, which raises `done` before going back to `ST_IDLE`. The transitions are:
- `ST_IDLE` to `ST_PUSH_BANK` on a native entry.
- `ST_IDLE` to `ST_PUSH_PCH` on an emulation entry.
- `ST_IDLE` to `ST_PULL_STAT` on a return.
- `ST_PULL_PCH` to `ST_PULL_BANK` in native mode, or to `ST_LAST_RD` in emulation mode.
- Every other state has a single successor.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `resume`, `bus_we`, `bus_re` and `vec_pull` are all 0, and a write and a read are never issued in the same cycle.
- R2: A native entry writes four bytes: the program bank at SP, PC high at SP-1, PC low at SP-2 and the status byte at SP-3. The final `sp_out` is SP-4.
- R3: An emulation entry writes three bytes: PC high, PC low and status, at {0x01, L}, {0x01, L-1} and {0x01, L-2}, where L is the low byte of the stack pointer. The low byte wraps modulo 256 and the high byte stays 0x01. The final `sp_out` is {0x01, L-3}.
- R4: After an entry, `pbr_out` is 0. `p_out` equals the input status with bit 3 (decimal) cleared and bit 2 (interrupt disable) set. For the non-maskable interrupt, bit 2 is left as it was.
- R5: `pc_out` is loaded with the byte at the vector address (low byte) and the byte at vector+1 (high byte). Native vectors: coprocessor 0xFFE4, break 0xFFE6, abort 0xFFE8, non-maskable 0xFFEA, maskable 0xFFEE. Emulation vectors: coprocessor 0xFFF4, abort 0xFFF8, non-maskable 0xFFFA, break and maskable share 0xFFFE.
- R6: The break and coprocessor traps save `pc_in`+2. The hardware sources save `pc_in` unchanged.
- R7: In emulation mode, bit 5 of the saved status is 1 for a break and 0 for every other source. In native mode the saved status equals `p_in`.
- R8: The maskable interrupt is accepted only while `p_in` bit 2 is 0. Break and coprocessor traps are accepted whatever the value of bit 2.
- R9: While `wai_act` is 1, `irq_lvl` is 1 and `p_in` bit 2 is 1, the block raises `resume` for a cycle. It issues no bus access and does not leave the idle state.
- R10: Simultaneous requests are served in this order: abort, non-maskable, break, coprocessor, maskable, return. The non-maskable request is taken on a rising edge of `nmi_in` and is held pending until it is served. A level held high causes only one entry.
- R11: A return reads status from SP+1, then PC low and PC high, and in native mode one more byte into the program bank. The stack pointer is incremented before each read. In emulation mode `pbr_out` takes `pbr_in`.
- R12: `vec_pull` is 1 in exactly the two cycles that read the vector bytes, and in no cycle of a return.
- R13: `done` is a single-cycle pulse, raised while `busy` is 1, and the result outputs are final in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| emu_mode | input | 1 | Emulation mode flag, latched when a request is accepted |
| irq_lvl | input | 1 | Maskable interrupt, level-sensitive |
| nmi_in | input | 1 | Non-maskable interrupt, edge-detected |
| abort_req | input | 1 | Abort request |
| brk_req | input | 1 | Break trap request from decode |
| cop_req | input | 1 | Coprocessor trap request from decode |
| rti_req | input | 1 | Return-from-interrupt request from decode |
| wai_act | input | 1 | Core is stalled in wait-for-interrupt |
| pc_in | input | 16 | Current PC (opcode address for traps) |
| pbr_in | input | 8 | Current program bank |
| p_in | input | 8 | Current status byte |
| sp_in | input | 16 | Current stack pointer |
| bus_rdata | input | 8 | Read data, valid one cycle after the read |
| bus_addr | output | 16 | Bank-zero byte address |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| vec_pull | output | 1 | Marks a vector byte read |
| pc_out | output | 16 | Resulting PC |
| pbr_out | output | 8 | Resulting program bank |
| p_out | output | 8 | Resulting status byte |
| sp_out | output | 16 | Resulting stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Results are final this cycle |
| resume | output | 1 | Masked interrupt ends a wait without a vector |

## Verification
Entries are driven from every source in both modes. Stack pointers are random, so the native pushes land anywhere in the bank, while emulation pushes are held in page one. A directed case starts the emulation stack at 0x0101, which makes the low byte wrap past 0x00. Each random entry is followed by a return from the same stack, and the bank byte shows whether the fourth pull happened. A mask-set interrupt with and without a pending wait separates the refusal case from the resume case. Raising abort, the non-maskable edge and the maskable level in the same cycle shows both the priority order and that the losing edge stays pending.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int BIT_IRQ_OFF = 2;
    localparam int BIT_DEC     = 3;
    localparam int BIT_BRKMARK = 5;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PUSH_BANK, ST_PUSH_PCH, ST_PUSH_PCL, ST_PUSH_STAT,
        ST_VEC_LO, ST_VEC_HI, ST_PULL_STAT, ST_PULL_PCL, ST_PULL_PCH,
        ST_PULL_BANK, ST_LAST_RD, ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_ABORT, SRC_NMI, SRC_BRK, SRC_COP, SRC_IRQ, SRC_RTI
    } src_e;

    typedef enum logic [2:0] {
        CAP_NONE, CAP_STAT, CAP_PCL, CAP_PCH, CAP_BANK
    } cap_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic nmi_in,
    input  logic abort_req,
    input  logic brk_req,
    input  logic cop_req,
    input  logic irq_lvl,
    input  logic rti_req,
    input  logic irq_masked,
    input  logic wai_act,
    output src_e pick,
    output logic resume_hit
);
    logic nmi_q;
    logic nmi_pend;

    always_comb begin
        if (abort_req)                     pick = SRC_ABORT;
        else if (nmi_pend)                 pick = SRC_NMI;
        else if (brk_req)                  pick = SRC_BRK;
        else if (cop_req)                  pick = SRC_COP;
        else if (irq_lvl && !irq_masked)   pick = SRC_IRQ;
        else if (rti_req)                  pick = SRC_RTI;
        else                               pick = SRC_NONE;
    end

    assign resume_hit = idle && (pick == SRC_NONE) && wai_act && irq_lvl && irq_masked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            if (nmi_in && !nmi_q)
                nmi_pend <= 1'b1;
            else if (idle && pick == SRC_NMI)
                nmi_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/trap_vec_map.sv
module trap_vec_map
    import trap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_NATIVE = 16'hFFE0,
    parameter logic [ADDR_W-1:0] BASE_EMU    = 16'hFFF0
) (
    input  src_e              src,
    input  logic              emu,
    output logic [ADDR_W-1:0] vec_addr
);
    logic [3:0] slot;

    always_comb begin
        unique case (src)
            SRC_COP:   slot = 4'h4;
            SRC_BRK:   slot = emu ? 4'hE : 4'h6;
            SRC_ABORT: slot = 4'h8;
            SRC_NMI:   slot = 4'hA;
            SRC_IRQ:   slot = 4'hE;
            default:   slot = 4'h0;
        endcase
    end

    assign vec_addr = (emu ? BASE_EMU : BASE_NATIVE) | {{(ADDR_W-4){1'b0}}, slot};
endmodule

// File: rtl/trap_sp_step.sv
module trap_sp_step
    import trap_pkg::*;
#(
    parameter bit               STEP_UP = 1'b0,
    parameter logic [BYTE_W-1:0] PAGE   = 8'h01
) (
    input  logic [ADDR_W-1:0] sp,
    input  logic              emu,
    output logic [ADDR_W-1:0] nxt
);
    logic [BYTE_W-1:0] lo;
    logic [ADDR_W-1:0] wide;

    generate
        if (STEP_UP) begin : g_up
            assign lo   = sp[BYTE_W-1:0] + 1'b1;
            assign wide = sp + 1'b1;
        end else begin : g_down
            assign lo   = sp[BYTE_W-1:0] - 1'b1;
            assign wide = sp - 1'b1;
        end
    endgenerate

    assign nxt = emu ? {PAGE, lo} : wide;
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE_NATIVE = 16'hFFE0,
    parameter logic [ADDR_W-1:0] VEC_BASE_EMU    = 16'hFFF0,
    parameter logic [BYTE_W-1:0] EMU_STACK_PAGE  = 8'h01,
    parameter int                TRAP_SKIP       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emu_mode,
    input  logic              irq_lvl,
    input  logic              nmi_in,
    input  logic              abort_req,
    input  logic              brk_req,
    input  logic              cop_req,
    input  logic              rti_req,
    input  logic              wai_act,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [BYTE_W-1:0] pbr_in,
    input  logic [BYTE_W-1:0] p_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic              vec_pull,
    output logic [ADDR_W-1:0] pc_out,
    output logic [BYTE_W-1:0] pbr_out,
    output logic [BYTE_W-1:0] p_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic              busy,
    output logic              done,
    output logic              resume
);
    localparam logic [ADDR_W-1:0] SKIP = ADDR_W'(TRAP_SKIP);

    seq_state_e state, state_nxt;
    src_e       pick, src_q;
    cap_e       cap_q;
    logic       emu_q, resume_hit, resume_q;
    logic [ADDR_W-1:0] pc_q, sp_q, sp_dn, sp_up, vec_addr;
    logic [BYTE_W-1:0] pbr_q, p_q, stat_push;

    trap_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .idle(state == ST_IDLE), .nmi_in(nmi_in),
        .abort_req(abort_req), .brk_req(brk_req), .cop_req(cop_req),
        .irq_lvl(irq_lvl), .rti_req(rti_req), .irq_masked(p_in[BIT_IRQ_OFF]),
        .wai_act(wai_act), .pick(pick), .resume_hit(resume_hit)
    );

    trap_vec_map #(.BASE_NATIVE(VEC_BASE_NATIVE), .BASE_EMU(VEC_BASE_EMU)) u_vec (
        .src(src_q), .emu(emu_q), .vec_addr(vec_addr)
    );

    trap_sp_step #(.STEP_UP(1'b0), .PAGE(EMU_STACK_PAGE)) u_sp_dn (
        .sp(sp_q), .emu(emu_q), .nxt(sp_dn)
    );

    trap_sp_step #(.STEP_UP(1'b1), .PAGE(EMU_STACK_PAGE)) u_sp_up (
        .sp(sp_q), .emu(emu_q), .nxt(sp_up)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (pick == SRC_RTI)       state_nxt = ST_PULL_STAT;
                else if (pick != SRC_NONE) state_nxt = emu_mode ? ST_PUSH_PCH : ST_PUSH_BANK;
            end
            ST_PUSH_BANK: state_nxt = ST_PUSH_PCH;
            ST_PUSH_PCH:  state_nxt = ST_PUSH_PCL;
            ST_PUSH_PCL:  state_nxt = ST_PUSH_STAT;
            ST_PUSH_STAT: state_nxt = ST_VEC_LO;
            ST_VEC_LO:    state_nxt = ST_VEC_HI;
            ST_VEC_HI:    state_nxt = ST_LAST_RD;
            ST_PULL_STAT: state_nxt = ST_PULL_PCL;
            ST_PULL_PCL:  state_nxt = ST_PULL_PCH;
            ST_PULL_PCH:  state_nxt = emu_q ? ST_LAST_RD : ST_PULL_BANK;
            ST_PULL_BANK: state_nxt = ST_LAST_RD;
            ST_LAST_RD:   state_nxt = ST_DONE;
            ST_DONE:      state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // Status image written to the stack
    always_comb begin
        stat_push = p_q;
        if (emu_q) stat_push[BIT_BRKMARK] = (src_q == SRC_BRK);
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= SRC_NONE;
            emu_q    <= 1'b0;
            cap_q    <= CAP_NONE;
            pc_q     <= '0;
            pbr_q    <= '0;
            p_q      <= '0;
            sp_q     <= '0;
            resume_q <= 1'b0;
        end else begin
            resume_q <= resume_hit;
            unique case (cap_q)
                CAP_STAT: p_q          <= bus_rdata;
                CAP_PCL:  pc_q[7:0]    <= bus_rdata;
                CAP_PCH:  pc_q[15:8]   <= bus_rdata;
                CAP_BANK: pbr_q        <= bus_rdata;
                default: ;
            endcase
            cap_q <= CAP_NONE;
            unique case (state)
                ST_IDLE: begin
                    if (pick != SRC_NONE) begin
                        src_q <= pick;
                        emu_q <= emu_mode;
                        pc_q  <= (pick == SRC_BRK || pick == SRC_COP) ? pc_in + SKIP : pc_in;
                        pbr_q <= pbr_in;
                        p_q   <= p_in;
                        sp_q  <= emu_mode ? {EMU_STACK_PAGE, sp_in[7:0]} : sp_in;
                    end
                end
                ST_PUSH_BANK, ST_PUSH_PCH, ST_PUSH_PCL: sp_q <= sp_dn;
                ST_PUSH_STAT: begin
                    sp_q              <= sp_dn;
                    pbr_q             <= '0;
                    p_q[BIT_DEC]      <= 1'b0;
                    if (src_q != SRC_NMI) p_q[BIT_IRQ_OFF] <= 1'b1;
                end
                ST_VEC_LO:    cap_q <= CAP_PCL;
                ST_VEC_HI:    cap_q <= CAP_PCH;
                ST_PULL_STAT: begin sp_q <= sp_up; cap_q <= CAP_STAT; end
                ST_PULL_PCL:  begin sp_q <= sp_up; cap_q <= CAP_PCL;  end
                ST_PULL_PCH:  begin sp_q <= sp_up; cap_q <= CAP_PCH;  end
                ST_PULL_BANK: begin sp_q <= sp_up; cap_q <= CAP_BANK; end
                default: ;
            endcase
        end
    end

    // Bus outputs
    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        vec_pull  = 1'b0;
        unique case (state)
            ST_PUSH_BANK: begin bus_addr = sp_q; bus_wdata = pbr_q;       bus_we = 1'b1; end
            ST_PUSH_PCH:  begin bus_addr = sp_q; bus_wdata = pc_q[15:8];  bus_we = 1'b1; end
            ST_PUSH_PCL:  begin bus_addr = sp_q; bus_wdata = pc_q[7:0];   bus_we = 1'b1; end
            ST_PUSH_STAT: begin bus_addr = sp_q; bus_wdata = stat_push;   bus_we = 1'b1; end
            ST_VEC_LO:    begin bus_addr = vec_addr;        bus_re = 1'b1; vec_pull = 1'b1; end
            ST_VEC_HI:    begin bus_addr = vec_addr + 1'b1; bus_re = 1'b1; vec_pull = 1'b1; end
            ST_PULL_STAT, ST_PULL_PCL, ST_PULL_PCH, ST_PULL_BANK: begin
                bus_addr = sp_up;
                bus_re   = 1'b1;
            end
            default: ;
        endcase
    end

    assign pc_out  = pc_q;
    assign pbr_out = pbr_q;
    assign p_out   = p_q;
    assign sp_out  = sp_q;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign resume  = resume_q;
endmodule

// File: rtl/trap_seq_checker.sv
module trap_seq_checker
    import trap_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        resume,
    input logic        bus_we,
    input logic        bus_re,
    input logic [15:0] bus_addr,
    input logic        vec_pull,
    input logic [7:0]  pbr_out,
    input logic        mode_emu,
    input logic [2:0]  src_code
);
    a_r1_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    a_r12_vec_pull_read: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pull |-> (bus_re && bus_addr[15:5] == 11'h7FF));

    a_r3_emu_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && mode_emu) |-> bus_addr[15:8] == 8'h01);

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r9_resume_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (!busy && !bus_we && !bus_re));

    a_r4_bank_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (done && src_code != 3'(SRC_RTI)) |-> pbr_out == 8'h00);
endmodule

bind trap_sequencer trap_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .resume(resume),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .vec_pull(vec_pull),
    .pbr_out(pbr_out), .mode_emu(emu_q), .src_code(src_q)
);

// File: tb/trap_sequencer_bench.sv
`timescale 1ns/1ps
module trap_sequencer_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic emu_mode = 0, irq_lvl = 0, nmi_in = 0, abort_req = 0, brk_req = 0;
    logic cop_req = 0, rti_req = 0, wai_act = 0;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic [7:0]  pbr_in = '0, p_in = '0, bus_rdata = '0;
    logic [15:0] bus_addr, pc_out, sp_out;
    logic [7:0]  bus_wdata, pbr_out, p_out;
    logic bus_we, bus_re, vec_pull, busy, done, resume;

    int checks = 0, errors = 0, n_wr = 0, n_vp = 0, n_busy = 0;
    logic [7:0] mem [logic [15:0]];
    logic [15:0] last_pcp, last_s0;
    logic [7:0]  last_st, last_pb;
    logic        last_em;

    always #2.5 clk = ~clk;

    trap_sequencer u_trap_sequencer (
        .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .irq_lvl(irq_lvl),
        .nmi_in(nmi_in), .abort_req(abort_req), .brk_req(brk_req), .cop_req(cop_req),
        .rti_req(rti_req), .wai_act(wai_act), .pc_in(pc_in), .pbr_in(pbr_in),
        .p_in(p_in), .sp_in(sp_in), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .vec_pull(vec_pull),
        .pc_out(pc_out), .pbr_out(pbr_out), .p_out(p_out), .sp_out(sp_out),
        .busy(busy), .done(done), .resume(resume)
    );

    function automatic logic [7:0] rdm(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (bus_we) mem[bus_addr] = bus_wdata;
        if (bus_re) bus_rdata <= rdm(bus_addr);
        if (bus_we) n_wr++;
        if (vec_pull) n_vp++;
        if (busy) n_busy++;
    end

    function automatic logic [7:0] vb(input logic [15:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    function automatic logic [15:0] vword(input logic [15:0] a);
        return {vb(a + 16'd1), vb(a)};
    endfunction

    // 1 abort, 2 nmi, 3 brk, 4 cop, 5 irq
    function automatic logic [15:0] vexp(input int src, input bit em);
        case (src)
            1:       return em ? 16'hFFF8 : 16'hFFE8;
            2:       return em ? 16'hFFFA : 16'hFFEA;
            3:       return em ? 16'hFFFE : 16'hFFE6;
            4:       return em ? 16'hFFF4 : 16'hFFE4;
            default: return em ? 16'hFFFE : 16'hFFEE;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic enter(input int src, input bit em, input logic [15:0] pc,
                         input logic [7:0] pb, input logic [7:0] ps, input logic [15:0] spv);
        logic [15:0] s0, pcp;
        logic [7:0]  st, pexp;
        @(negedge clk);
        emu_mode = em; pc_in = pc; pbr_in = pb; p_in = ps; sp_in = spv;
        n_wr = 0; n_vp = 0;
        case (src)
            1: abort_req = 1; 2: nmi_in = 1; 3: brk_req = 1; 4: cop_req = 1;
            default: irq_lvl = 1;
        endcase
        do @(negedge clk); while (!busy);
        abort_req = 0; brk_req = 0; cop_req = 0; irq_lvl = 0; nmi_in = 0;
        do @(negedge clk); while (!done);
        s0   = em ? {8'h01, spv[7:0]} : spv;
        pcp  = pc + ((src == 3 || src == 4) ? 16'd2 : 16'd0);
        st   = em ? ((ps & 8'hDF) | (src == 3 ? 8'h20 : 8'h00)) : ps;
        pexp = (ps & 8'hF7) | (src == 2 ? 8'h00 : 8'h04);
        if (em) begin
            check("R3 pch slot", rdm(s0), pcp[15:8]);
            check("R6 pcl slot", rdm({8'h01, 8'(s0[7:0] - 8'd1)}), pcp[7:0]);
            check("R7 stat slot", rdm({8'h01, 8'(s0[7:0] - 8'd2)}), st);
            check("R3 sp_out", sp_out, {8'h01, 8'(s0[7:0] - 8'd3)});
            check("R3 write count", n_wr, 3);
        end else begin
            check("R2 bank slot", rdm(s0), pb);
            check("R2 pch slot", rdm(s0 - 16'd1), pcp[15:8]);
            check("R6 pcl slot", rdm(s0 - 16'd2), pcp[7:0]);
            check("R7 stat slot", rdm(s0 - 16'd3), st);
            check("R2 sp_out", sp_out, s0 - 16'd4);
            check("R2 write count", n_wr, 4);
        end
        check("R5 pc from vector", pc_out, vword(vexp(src, em)));
        check("R4 bank zero", pbr_out, 8'h00);
        check("R4 status", p_out, pexp);
        check("R12 vector pulls", n_vp, 2);
        last_pcp = pcp; last_st = st; last_pb = pb; last_em = em; last_s0 = s0;
    endtask

    task automatic ret(input logic [7:0] pbv);
        @(negedge clk);
        emu_mode = last_em; sp_in = sp_out; pbr_in = pbv; p_in = 8'hFF;
        n_wr = 0; n_vp = 0;
        rti_req = 1;
        do @(negedge clk); while (!busy);
        rti_req = 0;
        do @(negedge clk); while (!done);
        check("R11 pc", pc_out, last_pcp);
        check("R11 status", p_out, last_st);
        check("R11 bank", pbr_out, last_em ? pbv : last_pb);
        check("R11 sp", sp_out, last_s0);
        check("R12 no pull on return", n_vp, 0);
        check("R11 no writes", n_wr, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL R13 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        void'($urandom(32'd2024));
        for (int a = 16'hFFE0; a <= 16'hFFFF; a++) mem[16'(a)] = vb(16'(a));
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 bus idle", {bus_we, bus_re, vec_pull, resume}, 4'b0000);
        rst_n = 1;
        @(negedge clk);

        // R8: masked maskable interrupt is refused
        p_in = 8'h04; n_busy = 0; irq_lvl = 1;
        repeat (12) @(negedge clk);
        check("R8 masked irq refused", n_busy, 0);

        // R9: wait ends without a vector
        n_wr = 0; n_vp = 0; seen = 0; wai_act = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (resume) seen = 1;
        end
        wai_act = 0; irq_lvl = 0;
        check("R9 resume seen", seen, 1);
        check("R9 no bus or busy", n_wr + n_vp + n_busy, 0);

        // R8: break taken with mask set
        enter(3, 0, 16'h2000, 8'h05, 8'h04, 16'h1FFF);
        check("R8 brk with mask", p_out[2], 1);

        // R3: emulation stack low byte wraps
        enter(5, 1, 16'h4321, 8'h12, 8'h00, 16'h0101);
        ret(8'h33);

        // R10: priority and pending edge
        @(negedge clk);
        emu_mode = 0; pc_in = 16'h1234; p_in = 8'h00; sp_in = 16'h3000;
        abort_req = 1; nmi_in = 1; irq_lvl = 1;
        do @(negedge clk); while (!busy);
        abort_req = 0; irq_lvl = 0;
        do @(negedge clk); while (!done);
        check("R10 abort first", pc_out, vword(16'hFFE8));
        @(negedge clk);
        do @(negedge clk); while (!done);
        check("R10 pending nmi next", pc_out, vword(16'hFFEA));
        @(negedge clk);
        n_busy = 0;
        repeat (12) @(negedge clk);
        check("R10 held nmi no retrigger", n_busy, 0);
        nmi_in = 0;

        for (int k = 0; k < 40; k++) begin
            int src;
            bit em;
            logic [7:0] ps;
            logic [15:0] spv;
            src = 1 + int'($urandom % 5);
            em  = 1'($urandom % 2);
            ps  = 8'($urandom);
            if (src == 5) ps[2] = 0;
            spv = em ? 16'($urandom) : 16'h0200 + 16'($urandom % 32'h8000);
            enter(src, em, 16'($urandom), 8'($urandom), ps, spv);
            ret(8'h5A);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule